// File: doc/BRIEF.md
# Compare-Match Down-Counter Timer

This block is a 32-bit down-counting timer with a small register port. It steps down by one on every clock where it is switched on and a tick-enable input is high. When the count runs out, it restarts either from a software-programmed load value or from the all-ones value, depending on a mode bit. A compare register is watched all the time. When the counter counts onto the compare value, a sticky flag is set. An interrupt line follows that flag whenever its enable bit is set.

Software uses five word registers: control, status, load, compare, and a read-only view of the counter. The control register holds the mode bits and two command bits. One command bit is a self-clearing soft reset. The other makes every load-register write go straight into the counter as well. A further mode bit makes switching the timer on preset the counter to the current restart value. Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `cmp_down_timer`

## Requirements
- R1: After reset, control reads 0, status reads 0, load reads 0xFFFFFFFF, compare reads 0, the counter reads 0xFFFFFFFF and irq is low. The register offsets are: control 0x00, status 0x04, load 0x08, compare 0x0C, counter 0x10.
- R2: A control write stores bits [25:0] only, and bits [31:26] read back as zero. The control bits are: bit 0 run, bit 1 preset-on-start, bit 2 compare interrupt enable, bit 3 reload mode, bit 16 soft reset, bit 17 immediate load.
- R3: The counter decreases by one on each rising edge where both the run bit and tick_en are 1. Otherwise it holds its value.
- R4: A step taken at count 0 restarts the counter. With reload mode (bit 3) set, it restarts from the load register. With reload mode clear, it restarts from 0xFFFFFFFF. The bit is sampled at the moment of the wrap.
- R5: A control write that changes run from 0 to 1 with preset-on-start (bit 1) set loads the counter with the restart value selected by the written reload bit. Without bit 1, or when run was already 1, the counter keeps its value.
- R6: A load-register write made while immediate load (bit 17) is stored loads the counter with the written value at the same edge. Without bit 17, the counter is unaffected.
- R7: Status bit 0 (the compare flag) is set at the edge where a count step puts the counter onto the compare value. This happens whatever the state of the interrupt enable.
- R8: In reload mode with a load value below the compare value, once the counter is below the compare value no further compare flag is raised, however many steps follow.
- R9: The compare flag stays set until a status write with bit 0 equal to 1 clears it. A status write with bit 0 equal to 0 leaves it set.
- R10: irq is high exactly when the compare flag and control bit 2 are both 1.
- R11: A control write with bit 16 set clears the compare flag and every control bit except run, which takes the written value. It also returns load, compare and counter to their reset values. Bit 16 reads back as 0.
- R12: Writes to the counter offset or to any unmapped offset change nothing. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count step qualifier |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the accessed register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Compare interrupt |

## Verification
Every write and every count step lands at a single rising edge. Register contents, the counter and the compare flag are therefore all due one edge after the stimulus. irq and rdata follow combinationally in that same cycle. The bench drives its inputs on falling edges and holds tick_en high for an exact number of rising edges. It then reads back through rdata just after the next falling edge, so each expected value counts exactly the edges that occurred. Expected counts for stepping, wraps, presets and compare hits are worked out from the requirements alone.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 5;
    localparam int CTRL_KEEP_W = 26;

    // control bit positions
    localparam int B_RUN        = 0;
    localparam int B_PRESET     = 1;
    localparam int B_CMP_IE     = 2;
    localparam int B_RELOAD     = 3;
    localparam int B_SOFT_RST   = 16;
    localparam int B_IMM_LOAD   = 17;
    localparam int B_FLAG       = 0;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_LOAD = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CMP  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h10;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_STAT,
        SEL_LOAD,
        SEL_CMP,
        SEL_CNT,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_FORCE,
        ACT_STEP
    } cnt_act_e;

    typedef struct packed {
        logic imm_load;
        logic reload;
        logic cmp_ie;
        logic run;
    } ctrl_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CTRL: return SEL_CTRL;
            OFS_STAT: return SEL_STAT;
            OFS_LOAD: return SEL_LOAD;
            OFS_CMP:  return SEL_CMP;
            OFS_CNT:  return SEL_CNT;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              flag_q,
    output logic [CNT_W-1:0]  rdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  load_q,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              soft_rst,
    output logic              force_en,
    output logic [CNT_W-1:0]  force_val,
    output logic              stat_clr
);

    localparam int PAD_W = CNT_W - CTRL_KEEP_W;

    reg_sel_e                 sel;
    logic [CTRL_KEEP_W-1:0]   ctrl_raw;
    logic [CTRL_KEEP_W-1:0]   ctrl_after_rst;
    logic                     wr_ctrl, wr_stat, wr_load, wr_cmp;
    logic                     start_preset, imm_write;

    assign sel     = decode_addr(addr);
    assign wr_ctrl = wr_en && (sel == SEL_CTRL);
    assign wr_stat = wr_en && (sel == SEL_STAT);
    assign wr_load = wr_en && (sel == SEL_LOAD);
    assign wr_cmp  = wr_en && (sel == SEL_CMP);

    assign ctrl.run      = ctrl_raw[B_RUN];
    assign ctrl.cmp_ie   = ctrl_raw[B_CMP_IE];
    assign ctrl.reload   = ctrl_raw[B_RELOAD];
    assign ctrl.imm_load = ctrl_raw[B_IMM_LOAD];

    assign soft_rst     = wr_ctrl && wdata[B_SOFT_RST];
    assign start_preset = wr_ctrl && !ctrl.run && wdata[B_RUN] && wdata[B_PRESET];
    assign imm_write    = wr_load && ctrl.imm_load;
    assign force_en     = start_preset || imm_write;
    assign stat_clr     = wr_stat && wdata[B_FLAG];

    always_comb begin
        if (imm_write) begin
            force_val = wdata;
        end else if (wdata[B_RELOAD]) begin
            force_val = load_q;
        end else begin
            force_val = '1;
        end
    end

    always_comb begin
        ctrl_after_rst        = '0;
        ctrl_after_rst[B_RUN] = wdata[B_RUN];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_raw <= '0;
            load_q   <= '1;
            cmp_q    <= '0;
        end else if (soft_rst) begin
            ctrl_raw <= ctrl_after_rst;
            load_q   <= '1;
            cmp_q    <= '0;
        end else begin
            if (wr_ctrl) ctrl_raw <= wdata[CTRL_KEEP_W-1:0];
            if (wr_load) load_q   <= wdata;
            if (wr_cmp)  cmp_q    <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata = {{PAD_W{1'b0}}, ctrl_raw};
            SEL_STAT: rdata = {{(CNT_W-1){1'b0}}, flag_q};
            SEL_LOAD: rdata = load_q;
            SEL_CMP:  rdata = cmp_q;
            SEL_CNT:  rdata = cnt_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/cdt_count.sv
module cdt_count
    import cdt_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             force_en,
    input  logic [CNT_W-1:0] force_val,
    input  logic             step_en,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_q,
    input  logic [CNT_W-1:0] cmp_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             match
);

    cnt_act_e         act;
    logic [CNT_W-1:0] stepped;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        if (cnt_q == '0) begin
            stepped = reload ? load_q : '1;
        end else begin
            stepped = cnt_q - CNT_W'(1);
        end
    end

    always_comb begin
        if (soft_rst)      act = ACT_CLEAR;
        else if (force_en) act = ACT_FORCE;
        else if (step_en)  act = ACT_STEP;
        else               act = ACT_HOLD;
    end

    always_comb begin
        unique case (act)
            ACT_CLEAR: cnt_d = '1;
            ACT_FORCE: cnt_d = force_val;
            ACT_STEP:  cnt_d = stepped;
            default:   cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '1;
        else     cnt_q <= cnt_d;
    end

    // only a counted step can hit the compare value
    assign match = (act == ACT_STEP) && (stepped == cmp_q);

endmodule

// File: rtl/cdt_flag.sv
module cdt_flag (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic set,
    input  logic clr,
    output logic flag_q
);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) flag_q <= 1'b0;
        else if (set)        flag_q <= 1'b1;
        else if (clr)        flag_q <= 1'b0;
    end

endmodule

// File: rtl/cmp_down_timer.sv
module cmp_down_timer
    import cdt_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_q, cmp_q, cnt_q, force_val;
    logic             soft_rst, force_en, stat_clr, match, flag_q;
    logic             run_w, reload_w, cmp_ie_w;

    assign run_w    = ctrl.run;
    assign reload_w = ctrl.reload;
    assign cmp_ie_w = ctrl.cmp_ie;

    cdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .cnt_q     (cnt_q),
        .flag_q    (flag_q),
        .rdata     (rdata),
        .ctrl      (ctrl),
        .load_q    (load_q),
        .cmp_q     (cmp_q),
        .soft_rst  (soft_rst),
        .force_en  (force_en),
        .force_val (force_val),
        .stat_clr  (stat_clr)
    );

    cdt_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .soft_rst  (soft_rst),
        .force_en  (force_en),
        .force_val (force_val),
        .step_en   (run_w && tick_en),
        .reload    (reload_w),
        .load_q    (load_q),
        .cmp_q     (cmp_q),
        .cnt_q     (cnt_q),
        .match     (match)
    );

    cdt_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .set      (match),
        .clr      (stat_clr),
        .flag_q   (flag_q)
    );

    assign irq = flag_q && cmp_ie_w;

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker
    import cdt_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wd_flag,
    input logic              wd_srst,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp_val,
    input logic              flag,
    input logic              run,
    input logic              reload,
    input logic              irq
);

    logic stepping, clr_wr, srst_wr;
    assign stepping = !wr_en && run && tick_en;
    assign clr_wr   = wr_en && (addr == OFS_STAT) && wd_flag;
    assign srst_wr  = wr_en && (addr == OFS_CTRL) && wd_srst;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !(run && tick_en)) |=> $stable(cnt)); // R3

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (stepping && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1))); // R3

    AST_WRAP_FREE: assert property (@(posedge clk) disable iff (rst)
        (stepping && cnt == '0 && !reload) |=> (cnt == '1)); // R4

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ($rose(flag) && !$past(wr_en)) |-> (cnt == cmp_val)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_wr && !srst_wr) |=> flag); // R9

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        !flag |-> !irq); // R10

    AST_SOFT_RST: assert property (@(posedge clk) disable iff (rst)
        srst_wr |=> (!flag && !irq && cnt == '1 && cmp_val == '0)); // R11

endmodule

bind cmp_down_timer cdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wd_flag (wdata[cdt_pkg::B_FLAG]),
    .wd_srst (wdata[cdt_pkg::B_SOFT_RST]),
    .cnt     (cnt_q),
    .cmp_val (cmp_q),
    .flag    (flag_q),
    .run     (run_w),
    .reload  (reload_w),
    .irq     (irq)
);

// File: tb/cmp_down_timer_bench.sv
module cmp_down_timer_bench;

    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_STAT = 5'h04;
    localparam logic [4:0] A_LOAD = 5'h08;
    localparam logic [4:0] A_CMP  = 5'h0C;
    localparam logic [4:0] A_CNT  = 5'h10;
    localparam logic [4:0] A_GAP  = 5'h14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cmp_down_timer u_cmp_down_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, $sformatf("read @%h", a), rdata, exp);
    endtask

    task automatic irq_is(input string req, input logic exp);
        #1;
        chk(req, "irq", {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        rd("R1", A_CTRL, 32'h0);
        rd("R1", A_STAT, 32'h0);
        rd("R1", A_LOAD, 32'hFFFF_FFFF);
        rd("R1", A_CMP,  32'h0);
        rd("R1", A_CNT,  32'hFFFF_FFFF);
        irq_is("R1", 1'b0);
    endtask

    task automatic t_ctrl_mask;
        wr(A_CTRL, 32'hFC00_0A04);
        rd("R2", A_CTRL, 32'h0000_0A04);
    endtask

    task automatic t_free_count;
        wr(A_CTRL, 32'h1);
        rd("R5", A_CNT, 32'hFFFF_FFFF);
        tick(5);
        rd("R3", A_CNT, 32'hFFFF_FFFA);
        repeat (3) @(negedge clk);
        rd("R3", A_CNT, 32'hFFFF_FFFA);
        wr(A_CTRL, 32'h0);
        tick(3);
        rd("R3", A_CNT, 32'hFFFF_FFFA);
    endtask

    task automatic t_imm_load;
        wr(A_CTRL, 32'h0002_0000);
        wr(A_LOAD, 32'd3);
        rd("R6", A_CNT, 32'd3);
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 32'd9);
        rd("R6", A_CNT, 32'd3);
        rd("R6", A_LOAD, 32'd9);
    endtask

    task automatic t_free_wrap;
        wr(A_CTRL, 32'h1);
        rd("R5", A_CNT, 32'd3);
        tick(3);
        rd("R3", A_CNT, 32'd0);
        rd("R7", A_STAT, 32'd1);
        irq_is("R10", 1'b0);
        tick(1);
        rd("R4", A_CNT, 32'hFFFF_FFFF);
        wr(A_STAT, 32'h0);
        rd("R9", A_STAT, 32'd1);
        wr(A_STAT, 32'h1);
        rd("R9", A_STAT, 32'd0);
    endtask

    task automatic t_reload_preset;
        wr(A_CTRL, 32'h0);
        wr(A_LOAD, 32'd10);
        wr(A_CTRL, 32'hA);
        wr(A_CTRL, 32'hB);
        rd("R5", A_CNT, 32'd10);
        tick(11);
        rd("R4", A_CNT, 32'd10);
        wr(A_STAT, 32'h1);
        wr(A_CMP, 32'd7);
        wr(A_CTRL, 32'hF);
        rd("R5", A_CNT, 32'd10);
        irq_is("R10", 1'b0);
        tick(3);
        rd("R7", A_CNT, 32'd7);
        rd("R7", A_STAT, 32'd1);
        irq_is("R10", 1'b1);
        wr(A_STAT, 32'h1);
        irq_is("R10", 1'b0);
    endtask

    task automatic t_unreachable;
        wr(A_LOAD, 32'd4);
        tick(8);
        rd("R8", A_CNT, 32'd4);
        rd("R8", A_STAT, 32'd0);
        tick(20);
        rd("R8", A_CNT, 32'd4);
        rd("R8", A_STAT, 32'd0);
        irq_is("R8", 1'b0);
    endtask

    task automatic t_mode_switch;
        wr(A_CTRL, 32'h7);
        rd("R5", A_CNT, 32'd4);
        tick(5);
        rd("R4", A_CNT, 32'hFFFF_FFFF);
    endtask

    task automatic t_soft_reset;
        wr(A_CMP, 32'hFFFF_FFFE);
        tick(1);
        rd("R7", A_STAT, 32'd1);
        irq_is("R10", 1'b1);
        wr(A_CTRL, 32'h0001_0005);
        rd("R11", A_CTRL, 32'h1);
        rd("R11", A_STAT, 32'h0);
        irq_is("R11", 1'b0);
        rd("R11", A_LOAD, 32'hFFFF_FFFF);
        rd("R11", A_CMP,  32'h0);
        rd("R11", A_CNT,  32'hFFFF_FFFF);
    endtask

    task automatic t_ignored;
        wr(A_CNT, 32'h0000_1234);
        wr(A_GAP, 32'h0000_0055);
        rd("R12", A_CNT,  32'hFFFF_FFFF);
        rd("R12", A_CTRL, 32'h1);
        rd("R12", A_LOAD, 32'hFFFF_FFFF);
        rd("R12", A_CMP,  32'h0);
        rd("R12", A_GAP,  32'h0);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl_mask();
        t_free_count();
        t_imm_load();
        t_free_wrap();
        t_reload_preset();
        t_unreachable();
        t_mode_switch();
        t_soft_reset();
        t_ignored();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual still running, expected finished");
            summary();
            $finish;
        end
    end

endmodule